// File: doc/BRIEF.md
# Raster Beam Position Counter

This block produces the horizontal and vertical beam position of a 263-line display, together with the horizontal and vertical blanking flags and one-cycle strobes at the start of horizontal blanking and at the start and end of vertical blanking. Each clock cycle is one pixel step. A mode input selects how far the horizontal count moves per step. In normal resolution it moves by two. In high resolution it moves by one.

The vertical count is not a plain line index. The frame opens with the count at all ones. It then rolls to zero and climbs through the visible area into the start of blanking. A few lines later it jumps up to a high value and climbs from there back to all ones. Logic downstream reads both counts as they stand. It uses the strobes to time work against the edges of blanking. A synchronous reset returns the beam to the first line of a frame.

Top module: `raster_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is `hcount`=0x000 and `vcount`=0x1FF, with `hblank`, `vblank`, `hblank_in`, `vblank_in` and `vblank_out` all 0.
- R2: When no wrap occurs, `hcount` grows by 2 per clock while `hires`=0 and by 1 per clock while `hires`=1.
- R3: When the next step would take `hcount` past 0x352, it becomes 0x000 instead. `vcount` changes only on that clock, so one line lasts 426 clocks in normal mode and 851 clocks in high-resolution mode.
- R4: At each line change, `vcount` moves from 0x1FF to 0x000 and from 0x0F5 to 0x1EF, and in every other case it goes up by one. A frame is therefore 263 lines, and line 241 reads 0x0F0.
- R5: `hblank` is 1 exactly while `hcount` is 0x280 or above, and it drops on the clock where `hcount` wraps to 0.
- R6: `vblank` is 1 exactly while `vcount` is in the range 0x0F0 to 0x0F5 or in the range 0x1EF to 0x1FE. It is 0 on the 0x1FF line and on lines 0x000 to 0x0EF.
- R7: `hblank_in` is high for a single clock, on the first clock of each line where `hcount` is at or above 0x280.
- R8: `vblank_in` is high for a single clock, on the first clock of the line where `vcount` reads 0x0F0.
- R9: `vblank_out` is high for a single clock, on the first clock of a line entered with `vcount` = 0x1FF. It is not raised by the state that reset leaves.
- R10: `vcount` never takes a value between 0x0F6 and 0x1EE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-step clock |
| rst | input | 1 | Synchronous reset, active high |
| hires | input | 1 | 1 selects high resolution (step 1), 0 selects normal (step 2) |
| hcount | output | 10 | Horizontal beam position |
| vcount | output | 9 | Vertical beam position (non-linear sequence) |
| hblank | output | 1 | Horizontal blanking flag |
| vblank | output | 1 | Vertical blanking flag |
| hblank_in | output | 1 | One-cycle strobe at the start of horizontal blanking |
| vblank_in | output | 1 | One-cycle strobe at the start of vertical blanking |
| vblank_out | output | 1 | One-cycle strobe at the end of vertical blanking |

## Verification
The bench runs one full normal-mode frame and goes on into the next. This catches a design that counts lines linearly, since it would show 0x0F6 on line 247 and not 0x1EF. It also catches a design that fires the end-of-blank strobe on the 0x000 line, which would put the pulse one line late. A design that raised `vblank_out` out of reset would fail on the very first sample. High-resolution runs, and random runs cut short by reset in mid-line, expose a step size or line length tied to the wrong mode. In normal mode such an error would show 0x281 or miss 0x352. Every cycle is compared against positions computed from the cycle index alone, so a blanking flag that is set or cleared one clock early or late is reported where it happens.

// File: rtl/raster_counter.sv
module raster_counter #(
  parameter int H_W = 10,
  parameter int V_W = 9,
  parameter logic [H_W-1:0] H_LAST = 10'h352,
  parameter logic [H_W-1:0] H_BLANK = 10'h280,
  parameter logic [V_W-1:0] V_TOP = 9'h1FF,
  parameter logic [V_W-1:0] V_BLANK = 9'h0F0,
  parameter logic [V_W-1:0] V_JUMP_FROM = 9'h0F5,
  parameter logic [V_W-1:0] V_JUMP_TO = 9'h1EF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hires,
  output logic [H_W-1:0] hcount,
  output logic [V_W-1:0] vcount,
  output logic           hblank,
  output logic           vblank,
  output logic           hblank_in,
  output logic           vblank_in,
  output logic           vblank_out
);

  localparam logic [H_W:0] STEP_HI = {{H_W{1'b0}}, 1'b1};
  localparam logic [H_W:0] STEP_LO = {{(H_W-1){1'b0}}, 2'b10};
  localparam logic [H_W:0] LAST_X = {1'b0, H_LAST};

  logic [H_W:0]   h_sum;
  logic           h_wrap;
  logic [H_W-1:0] h_nxt;
  logic [V_W-1:0] v_nxt;
  logic           hbi_nxt, vbi_nxt, vbo_nxt;

  assign h_sum   = {1'b0, hcount} + (hires ? STEP_HI : STEP_LO);
  assign h_wrap  = h_sum > LAST_X;
  assign h_nxt   = h_wrap ? '0 : h_sum[H_W-1:0];

  always_comb begin
    if (!h_wrap)                 v_nxt = vcount;
    else if (vcount == V_TOP)    v_nxt = '0;
    else if (vcount == V_JUMP_FROM) v_nxt = V_JUMP_TO;
    else                         v_nxt = vcount + 1'b1;
  end

  assign hbi_nxt = !h_wrap && (h_nxt >= H_BLANK) && (hcount < H_BLANK);
  assign vbi_nxt = h_wrap && (v_nxt == V_BLANK);
  assign vbo_nxt = h_wrap && (v_nxt == V_TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcount     <= '0;
      vcount     <= V_TOP;
      hblank     <= 1'b0;
      vblank     <= 1'b0;
      hblank_in  <= 1'b0;
      vblank_in  <= 1'b0;
      vblank_out <= 1'b0;
    end else begin
      hcount     <= h_nxt;
      vcount     <= v_nxt;
      hblank     <= !h_wrap && (h_nxt >= H_BLANK);
      hblank_in  <= hbi_nxt;
      vblank_in  <= vbi_nxt;
      vblank_out <= vbo_nxt;
      if (vbi_nxt)      vblank <= 1'b1;
      else if (vbo_nxt) vblank <= 1'b0;
    end
  end

  // R2: away from a wrap the horizontal position only moves forward
  assert_h_forward_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && hcount != '0) |-> (hcount > $past(hcount)));

  // R3: the line count holds still except when hcount returns to zero
  assert_v_on_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && hcount != '0) |-> $stable(vcount));

  assert_hbi_single_R7: assert property (@(posedge clk) disable iff (rst)
    hblank_in |=> !hblank_in);

  assert_hbi_flag_R5: assert property (@(posedge clk) disable iff (rst)
    hblank_in |-> (hblank && !$past(hblank)));

  assert_vbi_pos_R8: assert property (@(posedge clk) disable iff (rst)
    vblank_in |-> (vcount == V_BLANK && hcount == '0 && vblank));

  assert_vbo_pos_R9: assert property (@(posedge clk) disable iff (rst)
    vblank_out |-> (vcount == V_TOP && hcount == '0 && !vblank));

  assert_v_gap_R10: assert property (@(posedge clk) disable iff (rst)
    !(vcount > V_JUMP_FROM && vcount < V_JUMP_TO));

  assert_strobes_excl_R6: assert property (@(posedge clk) disable iff (rst)
    $countones({vblank_in, vblank_out}) <= 1);

endmodule

// File: tb/raster_counter_bench.sv
module raster_counter_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hires = 1'b0;
  logic [9:0] hcount;
  logic [8:0] vcount;
  logic hblank, vblank, hblank_in, vblank_in, vblank_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  raster_counter u_raster_counter (
    .clk(clk), .rst(rst), .hires(hires),
    .hcount(hcount), .vcount(vcount),
    .hblank(hblank), .vblank(vblank),
    .hblank_in(hblank_in), .vblank_in(vblank_in), .vblank_out(vblank_out)
  );

  function automatic int vseq(int line);
    if (line == 0) return 'h1FF;
    if (line <= 246) return line - 1;
    return 'h1EF + (line - 247);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_state(int k, bit hr);
    int len = hr ? 851 : 426;
    int pos = k % len;
    int ln = (k / len) % 263;
    int eh = hr ? pos : 2 * pos;
    int ev = vseq(ln);
    bit evb = (ev >= 'hF0 && ev <= 'hF5) || (ev >= 'h1EF && ev <= 'h1FE);
    chk(hcount == eh, "R2/R3 hcount", hcount, eh);
    chk(vcount == ev, "R4 vcount", vcount, ev);
    chk(hblank == (eh >= 'h280), "R5 hblank", hblank, eh >= 'h280);
    chk(vblank == evb, "R6 vblank", vblank, evb);
    chk(hblank_in == (eh == 'h280), "R7 hblank_in", hblank_in, eh == 'h280);
    chk(vblank_in == (pos == 0 && ev == 'hF0), "R8 vblank_in", vblank_in, pos == 0 && ev == 'hF0);
    chk(vblank_out == (pos == 0 && ev == 'h1FF && k != 0), "R9 vblank_out",
        vblank_out, pos == 0 && ev == 'h1FF && k != 0);
    chk(!(vcount > 'hF5 && vcount < 'h1EF), "R10 vcount gap", vcount, 0);
  endtask

  task automatic episode(bit hr, int n);
    hires = hr;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(hcount == 0 && vcount == 'h1FF, "R1 reset counts", {hcount, vcount}, 'h1FF);
    chk({hblank, vblank, hblank_in, vblank_in, vblank_out} == 5'b0, "R1 reset flags",
        {hblank, vblank, hblank_in, vblank_in, vblank_out}, 0);
    rst = 1'b0;
    for (int k = 0; k < n; k++) begin
      check_state(k, hr);
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    episode(1'b0, 263 * 426 + 430);
    episode(1'b1, 851 * 3 + 10);
    for (int i = 0; i < 6; i++) episode(1'($urandom % 2), 500 + int'($urandom % 3000));
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end
endmodule